// File: doc/BRIEF.md
# Timer Output Compare Unit

The unit watches a count taken from one of two 16-bit timers, or from both timers joined into one 32-bit count. It compares that count against a primary and a secondary compare value. A 3-bit mode value decides what a match does to the compare pin. The primary match can set, clear or toggle the pin. The pair of matches can form a single pulse or a repeating pulse train. In PWM mode, the secondary value is a duty buffer that is copied into the primary value at each period boundary.

A fault input is watched in one of the two PWM modes. When the fault input is asserted, the output driver is switched off in hardware. It stays off until the mode is written again. A sticky interrupt flag records the event that matters for each mode. Software reaches the unit through a simple write port with four word addresses: mode, primary compare, secondary compare and flag clear. The timers, pin multiplexing and the bus bridge are not part of the unit.

Top module: `ocmp_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `oc_pin`, `oc_oe` and `oc_irq` are 0. The mode is 000, and both compare values are 0.
- R2: Writing address 0 loads the mode from `wr_data[2:0]`. After that write, the pin is 1 for mode 010 and 0 for every other mode. In mode 001, a primary match drives the pin to 1 and sets the flag.
- R3: In mode 010, a primary match drives the pin to 0 and sets the flag.
- R4: In mode 011, every cycle with a primary match inverts the pin and sets the flag.
- R5: In mode 100, a primary match while the pin is 0 drives it to 1. A later secondary match drives it to 0 and sets the flag. After that, all matches are ignored until address 0 is written again.
- R6: In mode 101, the behaviour of R5 repeats without limit. Every secondary match that ends a pulse sets the flag.
- R7: When `wide` is 0, `tb_sel`=0 selects `tmr_a`/`per_a` and `tb_sel`=1 selects `tmr_b`/`per_b`. Only the low 16 bits of each compare value are compared.
- R8: When `wide` is 1, the count is {`tmr_b`,`tmr_a`}. All 32 bits of the compare value are compared, and `per_b` is the period strobe.
- R9: In modes 110 and 111, a period strobe copies the secondary value (address 2) into the primary value and drives the pin to 1. A primary match without a strobe drives the pin to 0. A secondary write during a period takes effect only at the next strobe.
- R10: In mode 111, `fault`=1 forces the pin to 0 and `oc_oe` to 0, and sets the flag. Both stay 0 after `fault` returns to 0, until address 0 is written. In mode 110, `fault` is ignored.
- R11: `oc_irq` holds until a write of 1 to bit 0 of address 3 clears it. Writing 0 there has no effect. A flag set in the same cycle as a clear wins.
- R12: In mode 000, the pin and `oc_oe` are 0 and matches are ignored. In every other mode, `oc_oe` is 1 unless a fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a | input | 16 | Count of time base A (low half when wide) |
| tmr_b | input | 16 | Count of time base B (high half when wide) |
| per_a | input | 1 | Period-match strobe of time base A |
| per_b | input | 1 | Period-match strobe of time base B |
| tb_sel | input | 1 | Time-base select in 16-bit use |
| wide | input | 1 | Use the joined 32-bit count |
| fault | input | 1 | Fault request, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 primary, 2 secondary, 3 flag clear |
| wr_data | input | 32 | Write data |
| oc_pin | output | 1 | Compare output level |
| oc_oe | output | 1 | Output driver enable |
| oc_irq | output | 1 | Sticky interrupt flag |

## Verification
Every state bit in the unit reaches a port within one or two cycles. A wrong pin level shows on `oc_pin` one edge after the match that produced it. A one-shot latch that fails to arm or disarm shows on the very next primary match, as an extra pulse or a missing one. A stale duty value shows only after the following period strobe, so the PWM checks run two whole periods with a duty change in between. A fault latch that clears by itself shows on `oc_oe` on the first cycle after the fault input drops.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    MD_OFF     = 3'b000,
    MD_HIGH    = 3'b001,
    MD_LOW     = 3'b010,
    MD_TOGGLE  = 3'b011,
    MD_ONESHOT = 3'b100,
    MD_PULSES  = 3'b101,
    MD_PWM     = 3'b110,
    MD_PWM_FLT = 3'b111
  } ocmp_mode_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_PRI  = 2'd1;
  localparam logic [1:0] A_SEC  = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;
endpackage

// File: rtl/ocmp_timebase.sv
module ocmp_timebase #(
  parameter int CW = 16
) (
  input  logic [CW-1:0]   tmr_a,
  input  logic [CW-1:0]   tmr_b,
  input  logic            per_a,
  input  logic            per_b,
  input  logic            tb_sel,
  input  logic            wide,
  output logic [2*CW-1:0] cnt,
  output logic            per
);
  always_comb begin
    if (wide) begin
      cnt = {tmr_b, tmr_a};
      per = per_b;
    end else begin
      cnt = {{CW{1'b0}}, (tb_sel ? tmr_b : tmr_a)};
      per = tb_sel ? per_b : per_a;
    end
  end
endmodule

// File: rtl/ocmp_compare.sv
module ocmp_compare #(
  parameter int CW = 16,
  parameter int NCH = 2
) (
  input  logic [2*CW-1:0]          cnt,
  input  logic                     wide,
  input  logic [NCH-1:0][2*CW-1:0] cmp,
  output logic [NCH-1:0]           hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hi_eq, lo_eq;
    assign lo_eq = (cnt[CW-1:0] == cmp[i][CW-1:0]);
    assign hi_eq = (cnt[2*CW-1:CW] == cmp[i][2*CW-1:CW]);
    assign hit[i] = lo_eq & (hi_eq | ~wide);
  end
endmodule

// File: rtl/ocmp_core.sv
module ocmp_core
  import ocmp_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          per,
  input  logic          hit_p,
  input  logic          hit_s,
  input  logic          fault,
  output logic [DW-1:0] pri_q,
  output logic [DW-1:0] sec_q,
  output logic          pin_q,
  output logic          oe,
  output logic          irq_q
);
  ocmp_mode_e mode_q;
  logic done_q, flt_q;
  logic q_n, done_n, flt_n, set_flag;
  logic mode_wr, clr_wr, pwm;

  assign mode_wr = wr_en && (wr_addr == A_MODE);
  assign clr_wr  = wr_en && (wr_addr == A_CLR) && wr_data[0];
  assign pwm     = (mode_q == MD_PWM) || (mode_q == MD_PWM_FLT);
  assign oe      = (mode_q != MD_OFF) && !flt_q;

  always_comb begin
    q_n = pin_q;
    done_n = done_q;
    flt_n = flt_q;
    set_flag = 1'b0;
    if (mode_wr) begin
      q_n = (wr_data[2:0] == MD_LOW);
      done_n = 1'b0;
      flt_n = 1'b0;
    end else begin
      unique case (mode_q)
        MD_OFF: q_n = 1'b0;
        MD_HIGH: if (hit_p) begin q_n = 1'b1; set_flag = 1'b1; end
        MD_LOW: if (hit_p) begin q_n = 1'b0; set_flag = 1'b1; end
        MD_TOGGLE: if (hit_p) begin q_n = ~pin_q; set_flag = 1'b1; end
        MD_ONESHOT, MD_PULSES: begin
          if (!done_q) begin
            if (hit_p && !pin_q) q_n = 1'b1;
            else if (hit_s && pin_q) begin
              q_n = 1'b0;
              set_flag = 1'b1;
              done_n = (mode_q == MD_ONESHOT);
            end
          end
        end
        default: begin
          if ((mode_q == MD_PWM_FLT) && (fault || flt_q)) begin
            set_flag = fault && !flt_q;
            flt_n = 1'b1;
            q_n = 1'b0;
          end else if (per) q_n = 1'b1;
          else if (hit_p) q_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_OFF;
      pri_q  <= '0;
      sec_q  <= '0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= ocmp_mode_e'(wr_data[2:0]);
      if (wr_en && wr_addr == A_PRI) pri_q <= wr_data;
      else if (pwm && per) pri_q <= sec_q;
      if (wr_en && wr_addr == A_SEC) sec_q <= wr_data;
      pin_q  <= q_n;
      done_q <= done_n;
      flt_q  <= flt_n;
      if (set_flag) irq_q <= 1'b1;
      else if (clr_wr) irq_q <= 1'b0;
    end
  end

  assert_off_low_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_OFF) |-> (!pin_q && !oe));

  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_ONESHOT && done_q && !mode_wr) |=> $stable(pin_q));

  assert_fault_kill_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_PWM_FLT && fault && !mode_wr) |=> (!pin_q && !oe && irq_q));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_wr) |=> irq_q);

  assert_duty_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (pwm && per && !mode_wr && !(wr_en && wr_addr == A_PRI)) |=> (pri_q == $past(sec_q)));
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tmr_a,
  input  logic [CW-1:0] tmr_b,
  input  logic          per_a,
  input  logic          per_b,
  input  logic          tb_sel,
  input  logic          wide,
  input  logic          fault,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [2*CW-1:0] wr_data,
  output logic          oc_pin,
  output logic          oc_oe,
  output logic          oc_irq
);
  localparam int DW = 2 * CW;

  logic [DW-1:0] cnt, pri, sec;
  logic per;
  logic [1:0] hit;
  logic [1:0][DW-1:0] cmp;

  assign cmp[0] = pri;
  assign cmp[1] = sec;

  ocmp_timebase #(.CW(CW)) tb_i (
    .tmr_a(tmr_a), .tmr_b(tmr_b), .per_a(per_a), .per_b(per_b),
    .tb_sel(tb_sel), .wide(wide), .cnt(cnt), .per(per)
  );

  ocmp_compare #(.CW(CW), .NCH(2)) cmp_i (
    .cnt(cnt), .wide(wide), .cmp(cmp), .hit(hit)
  );

  ocmp_core #(.DW(DW), .AW(2)) core_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per(per), .hit_p(hit[0]), .hit_s(hit[1]), .fault(fault),
    .pri_q(pri), .sec_q(sec), .pin_q(oc_pin), .oe(oc_oe), .irq_q(oc_irq)
  );
endmodule

// File: tb/ocmp_unit_tb_top.sv
module ocmp_unit_tb_top;
  typedef struct packed {
    logic wr; logic [1:0] adr; logic [31:0] dat;
    logic [15:0] ta; logic [15:0] tb;
    logic pa; logic pb; logic sel; logic wide; logic flt;
    logic pin; logic oe; logic irq; logic [3:0] req;
  } vec_t;

  // fields: wr adr dat | ta tb | pa pb sel wide flt | pin oe irq | requirement
  localparam vec_t TBL [0:60] = '{
    '{1,1,5,          0,0, 0,0,0,0,0, 0,0,0, 12}, // R12 load primary=5
    '{0,0,0,          5,0, 0,0,0,0,0, 0,0,0, 12}, // R12 match ignored when off
    '{1,0,1,          0,0, 0,0,0,0,0, 0,1,0, 2},  // R2 mode 001
    '{0,0,0,          4,0, 0,0,0,0,0, 0,1,0, 2},
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,1, 2},  // R2 set on match
    '{1,3,0,          0,0, 0,0,0,0,0, 1,1,1, 11}, // R11 write 0 no clear
    '{1,3,1,          0,0, 0,0,0,0,0, 1,1,0, 11}, // R11 clear
    '{1,0,2,          0,0, 0,0,0,0,0, 1,1,0, 3},  // R3 starts high
    '{0,0,0,          5,0, 0,0,0,0,0, 0,1,1, 3},  // R3 drive low
    '{1,3,1,          0,0, 0,0,0,0,0, 0,1,0, 11},
    '{1,0,3,          0,0, 0,0,0,0,0, 0,1,0, 4},  // R4 toggle mode
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,1, 4},
    '{0,0,0,          6,0, 0,0,0,0,0, 1,1,1, 4},
    '{0,0,0,          5,0, 0,0,0,0,0, 0,1,1, 4},
    '{1,3,1,          5,0, 0,0,0,0,0, 1,1,1, 11}, // R11 set beats clear
    '{1,2,9,          0,0, 0,0,0,0,0, 1,1,1, 4},  // secondary=9
    '{1,0,5,          0,0, 0,0,0,0,0, 0,1,1, 6},  // R6 mode 101
    '{1,3,1,          0,0, 0,0,0,0,0, 0,1,0, 11},
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,0, 6},
    '{0,0,0,          9,0, 0,0,0,0,0, 0,1,1, 6},
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,1, 6},
    '{0,0,0,          9,0, 0,0,0,0,0, 0,1,1, 6},
    '{1,0,4,          0,0, 0,0,0,0,0, 0,1,1, 5},  // R5 mode 100
    '{1,3,1,          0,0, 0,0,0,0,0, 0,1,0, 5},
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,0, 5},
    '{0,0,0,          9,0, 0,0,0,0,0, 0,1,1, 5},
    '{0,0,0,          5,0, 0,0,0,0,0, 0,1,1, 5},  // R5 ignored after pulse
    '{0,0,0,          9,0, 0,0,0,0,0, 0,1,1, 5},
    '{1,0,4,          0,0, 0,0,0,0,0, 0,1,1, 5},  // R5 rearm
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,1, 5},
    '{1,0,1,          0,0, 0,0,0,0,0, 0,1,1, 7},  // R7 mode 001 again
    '{1,3,1,          5,0, 0,0,1,0,0, 0,1,0, 7},  // R7 sel=1 ignores tmr_a
    '{0,0,0,          0,5, 0,0,1,0,0, 1,1,1, 7},  // R7 sel=1 uses tmr_b
    '{1,1,32'h00010005, 0,0, 0,0,0,0,0, 1,1,1, 8},
    '{1,0,1,          0,0, 0,0,0,0,0, 0,1,1, 8},
    '{1,3,1,          0,0, 0,0,0,0,0, 0,1,0, 8},
    '{0,0,0,          5,0, 0,0,0,0,0, 1,1,1, 7},  // R7 narrow uses low half only
    '{1,0,1,          0,0, 0,0,0,0,0, 0,1,1, 8},
    '{1,3,1,          0,0, 0,0,0,1,0, 0,1,0, 8},
    '{0,0,0,          5,0, 0,0,0,1,0, 0,1,0, 8},  // R8 high half differs
    '{0,0,0,          5,1, 0,0,0,1,0, 1,1,1, 8},  // R8 full 32-bit match
    '{1,0,6,          0,0, 0,0,0,0,0, 0,1,1, 9},  // R9 PWM
    '{1,2,3,          0,0, 0,0,0,0,0, 0,1,1, 9},
    '{0,0,0,          7,0, 1,0,0,0,0, 1,1,1, 9},  // R9 period -> high, duty=3
    '{1,2,6,          2,0, 0,0,0,0,0, 1,1,1, 9},
    '{0,0,0,          3,0, 0,0,0,0,0, 0,1,1, 9},  // R9 old duty still used
    '{0,0,0,          7,0, 1,0,0,0,0, 1,1,1, 9},
    '{0,0,0,          3,0, 0,0,0,0,0, 1,1,1, 9},
    '{0,0,0,          6,0, 0,0,0,0,0, 0,1,1, 9},  // R9 new duty
    '{0,0,0,          7,0, 1,0,0,0,0, 1,1,1, 9},
    '{0,0,0,          0,0, 0,0,0,0,1, 1,1,1, 10}, // R10 mode 110 ignores fault
    '{0,0,0,          6,0, 0,1,0,0,0, 0,1,1, 7},  // R7 per_b not selected
    '{1,0,7,          0,0, 0,0,0,0,0, 0,1,1, 10},
    '{1,3,1,          0,0, 0,0,0,0,0, 0,1,0, 10},
    '{0,0,0,          7,0, 1,0,0,0,0, 1,1,0, 10},
    '{0,0,0,          0,0, 0,0,0,0,1, 0,0,1, 10}, // R10 fault
    '{0,0,0,          7,0, 1,0,0,0,0, 0,0,1, 10}, // R10 stays off
    '{1,3,1,          0,0, 0,0,0,0,0, 0,0,0, 10},
    '{1,0,7,          0,0, 0,0,0,0,0, 0,1,0, 10}, // R10 rewrite releases
    '{0,0,0,          7,0, 1,0,0,0,0, 1,1,0, 10},
    '{1,0,0,          0,0, 0,0,0,0,0, 0,0,0, 12}  // R12 back to off
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] tmr_a = '0, tmr_b = '0;
  logic per_a = 0, per_b = 0, tb_sel = 0, wide = 0, fault = 0, wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic oc_pin, oc_oe, oc_irq;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ocmp_unit dut_i (
    .clk(clk), .rst(rst), .tmr_a(tmr_a), .tmr_b(tmr_b), .per_a(per_a), .per_b(per_b),
    .tb_sel(tb_sel), .wide(wide), .fault(fault), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .oc_pin(oc_pin), .oc_oe(oc_oe), .oc_irq(oc_irq)
  );

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({oc_pin, oc_oe, oc_irq} !== exp) begin
      errors++;
      $display("FAIL %s pin/oe/irq actual=%b expected=%b", req, {oc_pin, oc_oe, oc_irq}, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    wr_en = v.wr; wr_addr = v.adr; wr_data = v.dat;
    tmr_a = v.ta; tmr_b = v.tb; per_a = v.pa; per_b = v.pb;
    tb_sel = v.sel; wide = v.wide; fault = v.flt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 3'b000); // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'b000); // R1 first cycle after reset
    for (int i = 0; i < 61; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", TBL[i].req, i), {TBL[i].pin, TBL[i].oe, TBL[i].irq});
    end
    // R1: reset in the middle of activity clears mode and compare values
    drive('{1,1,5, 0,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    drive('{1,0,1, 0,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    drive('{0,0,0, 5,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    check("R1 pre", 3'b111);
    rst = 1'b1;
    @(negedge clk);
    check("R1 in reset", 3'b000);
    rst = 1'b0;
    drive('{0,0,0, 0,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    check("R1 after reset", 3'b000);
    // R1: primary back at 0, mode 001 written, count 0 must match
    drive('{1,0,1, 5,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    check("R1 primary cleared", 3'b010);
    drive('{0,0,0, 0,0, 0,0,0,0,0, 0,0,0, 1});
    @(negedge clk);
    check("R1 primary cleared match", 3'b111);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule